// File: doc/BRIEF.md
# Context-Tagged Translation Buffer with Entry Locking

This block is a fully associative translation buffer for 8 KB pages. Each slot holds a page tag (virtual address bits 63..13), a 13-bit address-space context, a physical page number and a set of attribute bits. A lookup request is answered one cycle later with a hit flag, the physical address, the attributes and a protection-fault flag. A slot whose global bit is set answers for any context.

Software fills the buffer through a write port. A new mapping replaces an existing mapping for the same page and context in place. Otherwise it goes to a free slot or, failing that, to the least recently used slot that is not locked. When every slot is locked the write is refused and flagged. A demap port removes one page, or every non-global slot of one context, in a single cycle.

All three request ports are valid-qualified and carry no ready signal. The block accepts a request on every cycle, so a source never stalls. The response and flag outputs are single-cycle pulses that the consumer must take when they appear. When a demap and a write arrive in the same cycle, the demap is performed and the write is dropped.

Top module: `ctx_tlb`

## Requirements
- R1: For a lookup accepted at a clock edge, `rsp_valid` is high during the following cycle and low in any cycle that does not follow a lookup; on a miss `rsp_pa`, `rsp_attr` and `rsp_fault` are all zero.
- R2: A lookup hits when a slot is valid, its stored tag equals `lk_va[63:13]`, and either its global bit is set or its context equals `lk_ctx`.
- R3: The write data word is decoded as follows: bit 63 valid, bits 62..61 size, bits 40..13 physical page number, bit 6 lock, bit 5 cacheable-physical, bit 4 cacheable-virtual, bit 3 side-effect, bit 2 privileged, bit 1 writable, bit 0 global. On a hit `rsp_pa` = {page number, `lk_va[12:0]`}.
- R4: `rsp_attr` packs the hit slot's attributes as [7:6] size, [5] cacheable-physical, [4] cacheable-virtual, [3] side-effect, [2] privileged, [1] writable, [0] global.
- R5: `rsp_fault` is set on a hit when the slot is privileged and `lk_user` is high, or when `lk_store` is high and the slot is not writable.
- R6: A write whose page and context match a valid slot (the same rule as R2) overwrites that slot in place. Every accepted write pulses `wr_done` in the next cycle.
- R7: A context demap (`dm_by_ctx`=1) invalidates every valid non-global slot whose context equals `dm_ctx` and leaves global slots intact.
- R8: A page demap (`dm_by_ctx`=0) invalidates every slot that a lookup of `dm_vpn`/`dm_ctx` would hit.
- R9: A write with no matching slot takes the lowest-index invalid slot. If no slot is invalid, it takes the unlocked slot that was least recently used. A lookup hit and an accepted write each make their slot the most recently used. When both happen in the same cycle, the write's slot is the one promoted.
- R10: When there is no matching slot and every slot is valid and locked, the write is refused: `wr_err` pulses in the next cycle, `wr_done` stays low and no slot changes.
- R11: When `dm_valid` and `wr_valid` are high together, the demap is carried out, the write is discarded, and neither `wr_done` nor `wr_err` pulses.
- R12: After reset all slots are invalid and `rsp_valid`, `wr_done` and `wr_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_va | input | 64 | Lookup virtual address |
| lk_ctx | input | 13 | Lookup context |
| lk_user | input | 1 | Lookup made in user mode |
| lk_store | input | 1 | Lookup is for a store |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | 41 | Translated physical address |
| rsp_attr | output | 8 | Attributes of the hit slot |
| rsp_fault | output | 1 | Protection fault on the hit |
| wr_valid | input | 1 | Write request valid |
| wr_va | input | 64 | Virtual address of the new mapping |
| wr_ctx | input | 13 | Context of the new mapping |
| wr_data | input | 64 | Data word of the new mapping |
| wr_done | output | 1 | Write accepted (one-cycle pulse) |
| wr_err | output | 1 | Write refused, all slots locked (one-cycle pulse) |
| dm_valid | input | 1 | Demap request valid |
| dm_by_ctx | input | 1 | 1 = context demap, 0 = page demap |
| dm_vpn | input | 51 | Page tag (virtual address bits 63..13) for a page demap |
| dm_ctx | input | 13 | Context for either demap |

## Verification
Every result appears exactly one clock after its request edge. This covers the lookup response, the `wr_done` and `wr_err` pulses, and the table state that a later lookup sees. The bench drives inputs just after a rising edge. It samples one time unit after the next rising edge, so each check reads the registered outputs of that single request. Effects that cannot be seen directly, such as eviction order, demap coverage and refused writes, are shown by lookups issued in the cycles that follow. No lookup is sent in the same cycle as the write or demap it probes.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
  localparam int VA_W   = 64;
  localparam int PAGE_W = 13;
  localparam int CTX_W  = 13;
  localparam int PA_W   = 41;
  localparam int TAG_W  = VA_W - PAGE_W;
  localparam int PPN_W  = PA_W - PAGE_W;
  localparam int ATTR_W = 8;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic [CTX_W-1:0] ctx;
    logic [PPN_W-1:0] ppn;
    logic [1:0]       size;
    logic             lock;
    logic             cp;
    logic             cv;
    logic             se;
    logic             priv;
    logic             wr;
    logic             glob;
  } tlb_entry_t;

  function automatic tlb_entry_t build_entry(input logic [VA_W-1:0] va,
                                             input logic [CTX_W-1:0] ctx,
                                             input logic [63:0] d);
    tlb_entry_t e;
    e.valid = d[63];
    e.size  = d[62:61];
    e.ppn   = d[PA_W-1:PAGE_W];
    e.lock  = d[6];
    e.cp    = d[5];
    e.cv    = d[4];
    e.se    = d[3];
    e.priv  = d[2];
    e.wr    = d[1];
    e.glob  = d[0];
    e.tag   = va[VA_W-1:PAGE_W];
    e.ctx   = ctx;
    return e;
  endfunction

  function automatic logic [ATTR_W-1:0] pack_attr(input tlb_entry_t e);
    return {e.size, e.cp, e.cv, e.se, e.priv, e.wr, e.glob};
  endfunction
endpackage

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match
  import ctx_tlb_pkg::*;
(
  input  tlb_entry_t       ent,
  input  logic [TAG_W-1:0] tag,
  input  logic [CTX_W-1:0] ctx,
  output logic             hit
);
  assign hit = ent.valid && (ent.tag == tag) && (ent.glob || (ent.ctx == ctx));
endmodule

// File: rtl/ctx_tlb_lru.sv
module ctx_tlb_lru #(
  parameter  int ENTRIES = 16,
  localparam int IW      = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IW-1:0]      touch_idx,
  input  logic [ENTRIES-1:0] free_mask,
  input  logic [ENTRIES-1:0] cand_mask,
  output logic [IW-1:0]      victim_idx,
  output logic               victim_ok
);
  // age 0 = most recently used; ages always form a permutation
  logic [IW-1:0] age [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ENTRIES; k++) age[k] <= IW'(k);
    end else if (touch_en) begin
      for (int k = 0; k < ENTRIES; k++) begin
        if (IW'(k) == touch_idx)           age[k] <= '0;
        else if (age[k] < age[touch_idx]) age[k] <= age[k] + 1'b1;
      end
    end
  end

  logic          found_free;
  logic [IW-1:0] best_age;

  always_comb begin
    found_free = 1'b0;
    victim_ok  = 1'b0;
    victim_idx = '0;
    best_age   = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (free_mask[k] && !found_free) begin
        found_free = 1'b1;
        victim_idx = IW'(k);
      end
    end
    if (found_free) begin
      victim_ok = 1'b1;
    end else begin
      for (int k = 0; k < ENTRIES; k++) begin
        if (cand_mask[k] && (!victim_ok || age[k] > best_age)) begin
          victim_ok  = 1'b1;
          victim_idx = IW'(k);
          best_age   = age[k];
        end
      end
    end
  end

  AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    victim_ok |-> cand_mask[victim_idx]); // R9
  AST_TOUCH_BECOMES_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age[$past(touch_idx)] == '0); // R9
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter  int ENTRIES = 16,
  localparam int IW      = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic              lk_user,
  input  logic              lk_store,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              rsp_fault,
  input  logic              wr_valid,
  input  logic [VA_W-1:0]   wr_va,
  input  logic [CTX_W-1:0]  wr_ctx,
  input  logic [63:0]       wr_data,
  output logic              wr_done,
  output logic              wr_err,
  input  logic              dm_valid,
  input  logic              dm_by_ctx,
  input  logic [TAG_W-1:0]  dm_vpn,
  input  logic [CTX_W-1:0]  dm_ctx
);
  tlb_entry_t         ent_q [ENTRIES];
  tlb_entry_t         wr_new;
  logic [ENTRIES-1:0] lk_match, wr_match, dm_pmatch, dm_cmatch;
  logic [ENTRIES-1:0] free_mask, cand_mask, vld_vec;

  assign wr_new = build_entry(wr_va, wr_ctx, wr_data);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    ctx_tlb_match u_lk (.ent(ent_q[g]), .tag(lk_va[VA_W-1:PAGE_W]), .ctx(lk_ctx), .hit(lk_match[g]));
    ctx_tlb_match u_wr (.ent(ent_q[g]), .tag(wr_va[VA_W-1:PAGE_W]), .ctx(wr_ctx), .hit(wr_match[g]));
    ctx_tlb_match u_dm (.ent(ent_q[g]), .tag(dm_vpn),               .ctx(dm_ctx), .hit(dm_pmatch[g]));
    assign dm_cmatch[g] = ent_q[g].valid && !ent_q[g].glob && (ent_q[g].ctx == dm_ctx);
    assign free_mask[g] = !ent_q[g].valid;
    assign cand_mask[g] = !ent_q[g].valid || !ent_q[g].lock;
    assign vld_vec[g]   = ent_q[g].valid;

    AST_CTX_DEMAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (dm_valid && dm_by_ctx && dm_cmatch[g]) |=> !ent_q[g].valid); // R7
  end

  // priority select of the matching slots
  logic          lk_hit, wr_hit;
  logic [IW-1:0] lk_idx, wr_idx;
  tlb_entry_t    lk_ent;

  always_comb begin
    lk_hit = |lk_match;
    wr_hit = |wr_match;
    lk_idx = '0;
    wr_idx = '0;
    lk_ent = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (lk_match[k]) begin
        lk_idx = IW'(k);
        lk_ent = ent_q[k];
      end
      if (wr_match[k]) wr_idx = IW'(k);
    end
  end

  logic unused_lk;
  assign unused_lk = ^{lk_ent.valid, lk_ent.tag, lk_ent.ctx, lk_ent.lock};

  // replacement
  logic          victim_ok, do_wr, wr_ok, touch_en;
  logic [IW-1:0] victim_idx, wr_slot, touch_idx;

  assign do_wr     = wr_valid && !dm_valid;
  assign wr_ok     = do_wr && (wr_hit || victim_ok);
  assign wr_slot   = wr_hit ? wr_idx : victim_idx;
  assign touch_en  = wr_ok || (lk_valid && lk_hit);
  assign touch_idx = wr_ok ? wr_slot : lk_idx;

  ctx_tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .free_mask(free_mask), .cand_mask(cand_mask),
    .victim_idx(victim_idx), .victim_ok(victim_ok));

  // slot storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ENTRIES; k++) ent_q[k] <= '0;
    end else begin
      for (int k = 0; k < ENTRIES; k++) begin
        if (dm_valid && (dm_by_ctx ? dm_cmatch[k] : dm_pmatch[k]))
          ent_q[k].valid <= 1'b0;
        else if (wr_ok && wr_slot == IW'(k))
          ent_q[k] <= wr_new;
      end
    end
  end

  // registered response and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_attr  <= '0;
      rsp_fault <= 1'b0;
      wr_done   <= 1'b0;
      wr_err    <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_hit;
      rsp_pa    <= (lk_valid && lk_hit) ? {lk_ent.ppn, lk_va[PAGE_W-1:0]} : '0;
      rsp_attr  <= (lk_valid && lk_hit) ? pack_attr(lk_ent) : '0;
      rsp_fault <= lk_valid && lk_hit &&
                   ((lk_ent.priv && lk_user) || (lk_store && !lk_ent.wr));
      wr_done   <= wr_ok;
      wr_err    <= do_wr && !wr_ok;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R1
  AST_MISS_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && rsp_attr == '0 && !rsp_fault)); // R1
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_hit && rsp_valid)); // R5
  AST_REFUSED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && !wr_ok) |=> $stable(vld_vec)); // R10
  AST_DEMAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_valid && wr_valid) |=> (!wr_done && !wr_err)); // R11
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_done && wr_err)); // R6
endmodule

// File: tb/sim_ctx_tlb.sv
module sim_ctx_tlb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        lk_valid = 0, lk_user = 0, lk_store = 0;
  logic [63:0] lk_va = '0;
  logic [12:0] lk_ctx = '0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [40:0] rsp_pa;
  logic [7:0]  rsp_attr;
  logic        wr_valid = 0;
  logic [63:0] wr_va = '0, wr_data = '0;
  logic [12:0] wr_ctx = '0;
  logic        wr_done, wr_err;
  logic        dm_valid = 0, dm_by_ctx = 0;
  logic [50:0] dm_vpn = '0;
  logic [12:0] dm_ctx = '0;

  ctx_tlb u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  function automatic logic [63:0] mkva(input logic [15:0] vpn, input logic [12:0] off);
    return {35'h0, vpn, off};
  endfunction

  function automatic logic [63:0] mkdata(input logic [15:0] ppn, input logic lock, input logic priv,
                                         input logic wrb, input logic glob);
    logic [63:0] d = '0;
    d[63] = 1'b1; d[40:13] = {12'h0, ppn};
    d[6] = lock; d[2] = priv; d[1] = wrb; d[0] = glob;
    return d;
  endfunction

  // all drives happen 1 time unit after a rising edge; results read 1 unit after the next
  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic lookup(input logic [15:0] vpn, input logic [12:0] off, input logic [12:0] ctx,
                        input logic user, input logic store);
    lk_valid = 1; lk_va = mkva(vpn, off); lk_ctx = ctx; lk_user = user; lk_store = store;
    @(posedge clk); #1;
    lk_valid = 0; lk_user = 0; lk_store = 0;
  endtask

  task automatic write(input logic [15:0] vpn, input logic [12:0] ctx, input logic [63:0] d);
    wr_valid = 1; wr_va = mkva(vpn, 13'h0); wr_ctx = ctx; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic demap(input logic byctx, input logic [15:0] vpn, input logic [12:0] ctx);
    dm_valid = 1; dm_by_ctx = byctx; dm_vpn = {35'h0, vpn}; dm_ctx = ctx;
    @(posedge clk); #1;
    dm_valid = 0;
  endtask

  localparam logic [1:0] OP_LK = 2'd0, OP_WR = 2'd1, OP_DC = 2'd2, OP_DP = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [15:0] vpn;
    logic [12:0] off;
    logic [12:0] ctx;
    logic [15:0] ppn;
    logic        priv, wrb, glob, user, store, eh, ef;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{OP_WR, 4'd6,  16'h0010, 13'h000,  13'd5, 16'h0100, 1'b0,1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b0},
    '{OP_LK, 4'd3,  16'h0010, 13'h123,  13'd5, 16'h0100, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b0}, // R2 R3
    '{OP_LK, 4'd2,  16'h0010, 13'h123,  13'd6, 16'h0000, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0}, // context mismatch
    '{OP_LK, 4'd2,  16'h0011, 13'h000,  13'd5, 16'h0000, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0}, // page mismatch
    '{OP_WR, 4'd6,  16'h0020, 13'h000,  13'd5, 16'h0200, 1'b1,1'b1,1'b1, 1'b0,1'b0, 1'b0,1'b0},
    '{OP_LK, 4'd5,  16'h0020, 13'h1FFF, 13'd9, 16'h0200, 1'b0,1'b0,1'b0, 1'b1,1'b0, 1'b1,1'b1}, // global + user priv
    '{OP_LK, 4'd5,  16'h0020, 13'h0004, 13'd9, 16'h0200, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b0},
    '{OP_LK, 4'd5,  16'h0010, 13'h0008, 13'd5, 16'h0100, 1'b0,1'b0,1'b0, 1'b0,1'b1, 1'b1,1'b0}, // store ok
    '{OP_WR, 4'd6,  16'h0030, 13'h000,  13'd5, 16'h0300, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0},
    '{OP_LK, 4'd5,  16'h0030, 13'h0010, 13'd5, 16'h0300, 1'b0,1'b0,1'b0, 1'b0,1'b1, 1'b1,1'b1}, // store to RO
    '{OP_WR, 4'd6,  16'h0010, 13'h000,  13'd5, 16'h0111, 1'b0,1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b0}, // overwrite R6
    '{OP_LK, 4'd6,  16'h0010, 13'h0abc, 13'd5, 16'h0111, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b0},
    '{OP_DC, 4'd7,  16'h0000, 13'h000,  13'd5, 16'h0000, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0}, // R7
    '{OP_LK, 4'd7,  16'h0010, 13'h000,  13'd5, 16'h0000, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0},
    '{OP_LK, 4'd7,  16'h0020, 13'h000,  13'd5, 16'h0200, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b0}, // global survives
    '{OP_DP, 4'd8,  16'h0020, 13'h000,  13'd1, 16'h0000, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0}, // R8
    '{OP_LK, 4'd8,  16'h0020, 13'h000,  13'd9, 16'h0000, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0}
  };

  initial begin
    do_reset();
    // R12: reset state
    chk("R12", "rsp_valid", rsp_valid, 0);
    chk("R12", "wr_done", wr_done, 0);
    chk("R12", "wr_err", wr_err, 0);
    lookup(16'h0010, 13'h0, 13'd5, 0, 0);
    chk("R12", "hit after reset", rsp_hit, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      string r = $sformatf("R%0d", v.req);
      case (v.op)
        OP_WR: begin
          write(v.vpn, v.ctx, mkdata(v.ppn, 1'b0, v.priv, v.wrb, v.glob));
          chk(r, "wr_done", wr_done, 1);
        end
        OP_DC: demap(1'b1, v.vpn, v.ctx);
        OP_DP: demap(1'b0, v.vpn, v.ctx);
        default: begin
          lookup(v.vpn, v.off, v.ctx, v.user, v.store);
          chk(r, "rsp_valid", rsp_valid, 1);
          chk(r, "rsp_hit", rsp_hit, v.eh);
          chk(r, "rsp_pa", rsp_pa, v.eh ? {12'h0, v.ppn, v.off} : 41'h0);
          chk(r, "rsp_fault", rsp_fault, v.ef);
        end
      endcase
    end

    // R1: no response in an idle cycle
    @(posedge clk); #1;
    chk("R1", "idle rsp_valid", rsp_valid, 0);

    // R4: attribute packing
    begin
      logic [63:0] d = mkdata(16'h0044, 1'b0, 1'b0, 1'b1, 1'b0);
      d[62:61] = 2'b10; d[5] = 1; d[4] = 1; d[3] = 1;
      write(16'h0040, 13'd4, d);
      lookup(16'h0040, 13'h0, 13'd4, 0, 0);
      chk("R4", "rsp_attr", rsp_attr, 8'hBA);
      chk("R3", "rsp_pa", rsp_pa, {12'h0, 16'h0044, 13'h0});
    end

    // R9: free slots fill first, then LRU among unlocked
    do_reset();
    for (int i = 0; i < 16; i++) write(16'h0100 + 16'(i), 13'd1, mkdata(16'h0500 + 16'(i), 0, 0, 1, 0));
    lookup(16'h0100, 13'h0, 13'd1, 0, 0);
    chk("R9", "oldest promoted by hit", rsp_hit, 1);
    write(16'h0200, 13'd1, mkdata(16'h0600, 0, 0, 1, 0));
    chk("R9", "evicting write done", wr_done, 1);
    lookup(16'h0101, 13'h0, 13'd1, 0, 0);
    chk("R9", "LRU page evicted", rsp_hit, 0);
    lookup(16'h0100, 13'h0, 13'd1, 0, 0);
    chk("R9", "recent page kept", rsp_hit, 1);
    lookup(16'h0200, 13'h0, 13'd1, 0, 0);
    chk("R9", "new page present", rsp_hit, 1);

    // R10: all locked refuses
    do_reset();
    for (int i = 0; i < 16; i++) write(16'h0300 + 16'(i), 13'd2, mkdata(16'h0700 + 16'(i), 1, 0, 1, 0));
    write(16'h0400, 13'd2, mkdata(16'h0800, 0, 0, 1, 0));
    chk("R10", "wr_err", wr_err, 1);
    chk("R10", "wr_done", wr_done, 0);
    lookup(16'h0400, 13'h0, 13'd2, 0, 0);
    chk("R10", "refused page absent", rsp_hit, 0);
    lookup(16'h0300, 13'h0, 13'd2, 0, 0);
    chk("R10", "locked page kept", rsp_hit, 1);
    write(16'h0305, 13'd2, mkdata(16'h0999, 1, 0, 1, 0));
    chk("R6", "in-place write with all locked", wr_done, 1);
    lookup(16'h0305, 13'h0, 13'd2, 0, 0);
    chk("R6", "in-place pa", rsp_pa, {12'h0, 16'h0999, 13'h0});

    // R11: demap and write together
    do_reset();
    write(16'h0050, 13'd2, mkdata(16'h0050, 0, 0, 1, 0));
    dm_valid = 1; dm_by_ctx = 1; dm_ctx = 13'd2;
    wr_valid = 1; wr_va = mkva(16'h0060, 13'h0); wr_ctx = 13'd3; wr_data = mkdata(16'h0060, 0, 0, 1, 0);
    @(posedge clk); #1;
    dm_valid = 0; wr_valid = 0;
    chk("R11", "wr_done", wr_done, 0);
    chk("R11", "wr_err", wr_err, 0);
    lookup(16'h0050, 13'h0, 13'd2, 0, 0);
    chk("R11", "demapped page", rsp_hit, 0);
    lookup(16'h0060, 13'h0, 13'd3, 0, 0);
    chk("R11", "dropped write", rsp_hit, 0);

    wrap_up();
  end
endmodule